// File: doc/BRIEF.md
# Cache Way Replacement Selector

This block chooses which way of a set-associative cache line is overwritten on the next refill. It keeps one small replacement record per line, updates that record from access and refill strobes, and presents a victim way for the line currently addressed. The victim appears combinationally, in the same cycle as the index and the lock bits. Three policies are available, chosen at elaboration. With the random policy a free-running counter names the victim. With least-recently-replaced, a one-bit record per line points at the way refilled longer ago. With least-recently-used, a full recency order per line is kept as a permutation index. A one-way (direct-mapped) build always answers way 0.

Each way of the addressed line may be locked. A locked way is never offered. The random and least-recently-replaced policies step to the next higher way index, wrapping, until they reach an unlocked one. The least-recently-used policy walks its order from oldest to newest. If every way is locked, a "none" flag is raised.

Named states and transitions. With least-recently-replaced, each line is in state NEXT0 or NEXT1, naming the way to be replaced. A refill of way 0 moves the line to NEXT1 and a refill of way 1 moves it to NEXT0. With least-recently-used, each line holds one of WAYS! orderings, and TOUCH(w) moves way w to the newest end. With random, the shared counter moves through COUNT0, COUNT1 and onward to COUNT(WAYS-1) and then wraps back.

Top module: `cache_victim_picker`

## Requirements
- R1: After reset, every line holds the order way 0 (oldest) to way WAYS-1 (newest) for least-recently-used, or NEXT0 for least-recently-replaced. The random counter holds 0. With no locks the victim of every line is way 0.
- R2: Random policy: the victim is the value of a counter that is 1 bit wide for 2 ways and 2 bits wide for 3 or 4 ways. The counter advances by one on every clock after reset and wraps at WAYS-1. It is shared by all lines.
- R3: Least-recently-replaced policy (legal for 2 ways only; other way counts fall back to least-recently-used): one bit per line names the way not refilled most recently. Only a refill changes it, and an access has no effect.
- R4: Least-recently-used policy: the victim is the way of the addressed line that was accessed or refilled longest ago. Every accepted access or refill makes that way the newest. The state per line is 1, 3 or 5 bits for 2, 3 or 4 ways.
- R5: Replacement state is per line: an update to one line leaves the victim of every other line unchanged.
- R6: A way whose bit in way_lock (bit i = way i) is set is never the victim. Random and least-recently-replaced step from the policy's pick to the next higher way index, modulo WAYS. Least-recently-used takes the oldest unlocked way.
- R7: When all WAYS lock bits are set, victim_none is 1 and victim_way is 0. A refill in that cycle changes no state.
- R8: With WAYS = 1, victim_way is always 0, and victim_none equals way_lock[0].
- R9: A refill takes the way shown on victim_way in that cycle. When refill_valid and acc_valid are both high, the access is ignored.
- R10: An access whose acc_way is not below WAYS is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_idx | input | clog2(LINES) | Line whose victim is shown and whose state is updated |
| acc_valid | input | 1 | A hit access to line_idx occurred |
| acc_way | input | max(1,clog2(WAYS)) | Way that was hit |
| refill_valid | input | 1 | The current victim of line_idx is being refilled |
| way_lock | input | WAYS | Lock bit of each way of line_idx |
| victim_way | output | max(1,clog2(WAYS)) | Way to replace next |
| victim_none | output | 1 | All ways locked; no victim available |

## Verification
The victim is a direct, combinational view of the addressed line's record. A wrong update therefore shows at victim_way in the very next cycle, as soon as that line is addressed again. The bench reads back the whole record of every line after each update, not only the oldest way. It sweeps every lock pattern across every line, so a recency order that is wrong in any position becomes visible at the ports. Corruption of a neighbouring line shows in the same sweep. A counter for the random policy that stalls or mis-wraps shows within WAYS cycles.

// File: rtl/vpick_pkg.sv
package vpick_pkg;

    typedef enum logic [1:0] {
        POL_RANDOM = 2'd0,
        POL_LRR    = 2'd1,
        POL_LRU    = 2'd2
    } vpick_policy_e;

    localparam int MAX_WAYS = 4;

    typedef logic [1:0]                   way_t;
    typedef logic [MAX_WAYS-1:0][1:0]     order_t;  // [0] oldest

    function automatic int fact(input int n);
        int r;
        r = 1;
        for (int i = 2; i <= MAX_WAYS; i++) begin
            if (i <= n) r = r * i;
        end
        return r;
    endfunction

    // Permutation index -> ordering (Lehmer digits, oldest first)
    function automatic order_t lru_decode(input logic [4:0] code, input int w);
        order_t              o;
        logic [MAX_WAYS-1:0] used;
        int                  rem;
        int                  d;
        int                  cnt;
        o    = '0;
        used = '0;
        rem  = int'(code);
        for (int i = 0; i < MAX_WAYS; i++) begin
            if (i < w) begin
                d   = rem / fact(w - 1 - i);
                rem = rem % fact(w - 1 - i);
                cnt = 0;
                for (int k = 0; k < MAX_WAYS; k++) begin
                    if (k < w && !used[k]) begin
                        if (cnt == d) begin
                            o[i]    = way_t'(k);
                            used[k] = 1'b1;
                        end
                        cnt++;
                    end
                end
            end
        end
        return o;
    endfunction

    function automatic logic [4:0] lru_encode(input order_t o, input int w);
        int acc;
        int d;
        acc = 0;
        for (int i = 0; i < MAX_WAYS; i++) begin
            if (i < w) begin
                d = 0;
                for (int j = 0; j < MAX_WAYS; j++) begin
                    if (j > i && j < w && o[j] < o[i]) d++;
                end
                acc = acc + d * fact(w - 1 - i);
            end
        end
        return 5'(acc);
    endfunction

    // Move way x to the newest end
    function automatic order_t lru_touch(input order_t o, input way_t x, input int w);
        order_t n;
        int     p;
        n = o;
        p = 0;
        for (int i = 0; i < MAX_WAYS; i++) begin
            if (i < w && o[i] != x) begin
                n[p] = o[i];
                p++;
            end
        end
        n[w-1] = x;
        return n;
    endfunction

endpackage

// File: rtl/vpick_free_ctr.sv
module vpick_free_ctr
    import vpick_pkg::*;
#(
    parameter int MODULUS = 4,
    localparam int CW = (MODULUS <= 2) ? 1 : 2
) (
    input  logic clk,
    input  logic rst_n,
    output way_t value
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q == CW'(MODULUS - 1)) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign value = way_t'(cnt_q);

endmodule

// File: rtl/vpick_rotate_pick.sv
module vpick_rotate_pick
    import vpick_pkg::*;
#(
    parameter int WAYS = 4
) (
    input  way_t                start,
    input  logic [MAX_WAYS-1:0] locked,
    output way_t                pick,
    output logic                none
);

    way_t cand;
    logic found;

    always_comb begin
        pick  = '0;
        found = 1'b0;
        cand  = '0;
        for (int s = 0; s < WAYS; s++) begin
            cand = way_t'((int'(start) + s) % WAYS);
            if (!found && !locked[cand]) begin
                pick  = cand;
                found = 1'b1;
            end
        end
        none = !found;
    end

endmodule

// File: rtl/vpick_state_ram.sv
module vpick_state_ram #(
    parameter int LINES = 16,
    parameter int SW    = 5,
    localparam int IW   = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] idx,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_state,
    output logic [SW-1:0] rd_state
);

    logic [SW-1:0] mem [LINES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[idx] <= wr_state;
        end
    end

    assign rd_state = mem[idx];

    // R5: a line's record holds while nothing writes it
    a_r5_line_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (idx != $past(idx) || rd_state == $past(rd_state)));

endmodule

// File: rtl/cache_victim_picker.sv
module cache_victim_picker
    import vpick_pkg::*;
#(
    parameter int            WAYS   = 4,
    parameter int            LINES  = 16,
    parameter vpick_policy_e POLICY = POL_LRU,
    localparam int WW = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int IW = (LINES > 1) ? $clog2(LINES) : 1,
    localparam int SW = (WAYS > 1) ? $clog2(fact(WAYS)) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IW-1:0]   line_idx,
    input  logic            acc_valid,
    input  logic [WW-1:0]   acc_way,
    input  logic            refill_valid,
    input  logic [WAYS-1:0] way_lock,
    output logic [WW-1:0]   victim_way,
    output logic            victim_none
);

    logic [MAX_WAYS-1:0] lk_x;
    logic                unused_inputs;

    assign lk_x          = MAX_WAYS'(way_lock);
    assign unused_inputs = ^{line_idx, acc_valid, acc_way, refill_valid, way_lock};

    if (WAYS == 1) begin : g_dm
        assign victim_way  = '0;
        assign victim_none = way_lock[0];

    end else if (POLICY == POL_RANDOM) begin : g_rnd
        way_t ctr;
        way_t pk;
        logic nn;

        vpick_free_ctr #(.MODULUS(WAYS)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .value (ctr)
        );

        vpick_rotate_pick #(.WAYS(WAYS)) u_pick (
            .start  (ctr),
            .locked (lk_x),
            .pick   (pk),
            .none   (nn)
        );

        assign victim_way  = WW'(pk);
        assign victim_none = nn;

        // R2: with no locks the offered way moves every cycle
        a_r2_counter_moves: assert property (@(posedge clk) disable iff (!rst_n)
            (lk_x == '0) |=> (lk_x != '0 || victim_way != $past(victim_way)));

    end else if (POLICY == POL_LRR && WAYS == 2) begin : g_lrr
        logic st_q;
        logic st_we;
        way_t pk;
        logic nn;

        vpick_state_ram #(.LINES(LINES), .SW(1)) u_state (
            .clk      (clk),
            .rst_n    (rst_n),
            .idx      (line_idx),
            .wr_en    (st_we),
            .wr_state (~pk[0]),
            .rd_state (st_q)
        );

        vpick_rotate_pick #(.WAYS(2)) u_pick (
            .start  ({1'b0, st_q}),
            .locked (lk_x),
            .pick   (pk),
            .none   (nn)
        );

        assign st_we       = refill_valid && !nn;
        assign victim_way  = WW'(pk);
        assign victim_none = nn;

        // R3: a refill hands the next replacement to the other way
        a_r3_refill_alternates: assert property (@(posedge clk) disable iff (!rst_n)
            (refill_valid && !victim_none) |=>
                (line_idx != $past(line_idx) || lk_x != '0 || victim_way != $past(victim_way)));

    end else begin : g_lru
        logic [SW-1:0] st_q;
        logic [SW-1:0] st_d;
        logic [4:0]    code_n;
        logic          st_we;
        order_t        ord;
        way_t          tw;
        logic [WW-1:0] vw;
        logic          vn;

        vpick_state_ram #(.LINES(LINES), .SW(SW)) u_state (
            .clk      (clk),
            .rst_n    (rst_n),
            .idx      (line_idx),
            .wr_en    (st_we),
            .wr_state (st_d),
            .rd_state (st_q)
        );

        assign ord = lru_decode(5'(st_q), WAYS);

        always_comb begin
            vw = '0;
            vn = 1'b1;
            for (int i = WAYS - 1; i >= 0; i--) begin
                if (!lk_x[ord[i]]) begin
                    vw = WW'(ord[i]);
                    vn = 1'b0;
                end
            end
        end

        assign tw     = refill_valid ? way_t'(vw) : way_t'(acc_way);
        assign code_n = lru_encode(lru_touch(ord, tw, WAYS), WAYS);
        assign st_d   = code_n[SW-1:0];
        assign st_we  = refill_valid ? !vn : (acc_valid && int'(acc_way) < WAYS);

        assign victim_way  = vw;
        assign victim_none = vn;

        // R4: a way just accessed is no longer the oldest
        a_r4_touched_not_oldest: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_valid && !refill_valid && int'(acc_way) < WAYS) |=>
                (line_idx != $past(line_idx) || lk_x != '0 || victim_way != $past(acc_way)));
    end

    // R6: the offered way is never locked
    a_r6_victim_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        !victim_none |-> !lk_x[way_t'(victim_way)]);

    // R7: none flag exactly when every way is locked
    a_r7_none_all_locked: assert property (@(posedge clk) disable iff (!rst_n)
        victim_none == (&way_lock));

endmodule

// File: tb/cache_victim_picker_tb.sv
`timescale 1ns/1ps
module cache_victim_picker_tb;
    import vpick_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    int compared   = 0;
    int mismatched = 0;
    bit done       = 1'b0;
    int unsigned seed = 32'h1234_5678;

    // 4-way LRU
    logic [1:0] a_idx, a_aw, a_vw;
    logic       a_acc, a_rf, a_vn;
    logic [3:0] a_lk;
    // 3-way LRU
    logic [1:0] b_idx, b_aw, b_vw;
    logic       b_acc, b_rf, b_vn;
    logic [2:0] b_lk;
    // 2-way LRR
    logic [1:0] c_idx;
    logic [0:0] c_aw, c_vw;
    logic       c_acc, c_rf, c_vn;
    logic [1:0] c_lk;
    // 4-way random
    logic [1:0] d_vw;
    logic       d_vn;
    logic [3:0] d_lk;
    // direct mapped
    logic [1:0] e_idx;
    logic [0:0] e_aw, e_vw;
    logic       e_acc, e_rf, e_vn;
    logic [0:0] e_lk;

    cache_victim_picker #(.WAYS(4), .LINES(4), .POLICY(POL_LRU)) u_dut (
        .clk(clk), .rst_n(rst_n), .line_idx(a_idx), .acc_valid(a_acc), .acc_way(a_aw),
        .refill_valid(a_rf), .way_lock(a_lk), .victim_way(a_vw), .victim_none(a_vn));
    cache_victim_picker #(.WAYS(3), .LINES(4), .POLICY(POL_LRU)) u_dut_l3 (
        .clk(clk), .rst_n(rst_n), .line_idx(b_idx), .acc_valid(b_acc), .acc_way(b_aw),
        .refill_valid(b_rf), .way_lock(b_lk), .victim_way(b_vw), .victim_none(b_vn));
    cache_victim_picker #(.WAYS(2), .LINES(4), .POLICY(POL_LRR)) u_dut_rr (
        .clk(clk), .rst_n(rst_n), .line_idx(c_idx), .acc_valid(c_acc), .acc_way(c_aw),
        .refill_valid(c_rf), .way_lock(c_lk), .victim_way(c_vw), .victim_none(c_vn));
    cache_victim_picker #(.WAYS(4), .LINES(4), .POLICY(POL_RANDOM)) u_dut_rn (
        .clk(clk), .rst_n(rst_n), .line_idx(2'd0), .acc_valid(1'b0), .acc_way(2'd0),
        .refill_valid(1'b0), .way_lock(d_lk), .victim_way(d_vw), .victim_none(d_vn));
    cache_victim_picker #(.WAYS(1), .LINES(4), .POLICY(POL_LRU)) u_dut_dm (
        .clk(clk), .rst_n(rst_n), .line_idx(e_idx), .acc_valid(e_acc), .acc_way(e_aw),
        .refill_valid(e_rf), .way_lock(e_lk), .victim_way(e_vw), .victim_none(e_vn));

    // ---------------- bench models ----------------
    int mo [2][4][4];   // recency order per LRU bench, oldest first
    int mw [2];
    int nb [4];         // LRR next way per line
    int mc = 0;         // random counter model

    always @(posedge clk) begin
        if (!rst_n) mc <= 0;
        else        mc <= (mc + 1) % 4;
    end

    function automatic int unsigned rnd();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed >> 8;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    // ---------------- LRU helpers ----------------
    function automatic int get_lru(input int d);
        if (d == 0) return a_vn ? 100 + int'(a_vw) : int'(a_vw);
        return b_vn ? 100 + int'(b_vw) : int'(b_vw);
    endfunction

    task automatic drive_lru(input int d, input int ln, input bit acc, input int aw,
                             input bit rf, input logic [3:0] lk);
        if (d == 0) begin
            a_idx = 2'(ln); a_acc = acc; a_aw = 2'(aw); a_rf = rf; a_lk = lk;
        end else begin
            b_idx = 2'(ln); b_acc = acc; b_aw = 2'(aw); b_rf = rf; b_lk = lk[2:0];
        end
    endtask

    function automatic int lru_exp(input int d, input int ln, input logic [3:0] lk);
        for (int i = 0; i < mw[d]; i++) begin
            if (!lk[mo[d][ln][i]]) return mo[d][ln][i];
        end
        return 100;
    endfunction

    task automatic lru_touch_m(input int d, input int ln, input int w);
        int t [4];
        int p;
        p = 0;
        for (int i = 0; i < mw[d]; i++) begin
            if (mo[d][ln][i] != w) begin
                t[p] = mo[d][ln][i];
                p++;
            end
        end
        t[mw[d]-1] = w;
        for (int i = 0; i < mw[d]; i++) mo[d][ln][i] = t[i];
    endtask

    task automatic lru_sweep(input int d, input int touched, input string ttag, input string otag);
        int full;
        full = (1 << mw[d]) - 1;
        for (int ln = 0; ln < 4; ln++) begin
            for (int lk = 0; lk <= full; lk++) begin
                drive_lru(d, ln, 1'b0, 0, 1'b0, 4'(lk));
                #1;
                chk(lk == full ? "R7" : (lk != 0 ? "R6" : (ln == touched ? ttag : otag)),
                    get_lru(d), lru_exp(d, ln, 4'(lk)));
            end
        end
    endtask

    task automatic lru_step(input int d, input int ln, input bit acc, input int aw,
                            input bit rf, input logic [3:0] lk);
        int    ev;
        string tt;
        @(negedge clk);
        drive_lru(d, ln, acc, aw, rf, lk);
        #1;
        ev = lru_exp(d, ln, lk);
        if (rf) chk(acc ? "R9" : (ev == 100 ? "R7" : "R6"), get_lru(d), ev);
        @(posedge clk);
        if (rf) begin
            if (ev != 100) lru_touch_m(d, ln, ev);
        end else if (acc && aw < mw[d]) begin
            lru_touch_m(d, ln, aw);
        end
        tt = (rf && acc) ? "R9" : ((acc && !rf && aw >= mw[d]) ? "R10" : "R4");
        @(negedge clk);
        drive_lru(d, ln, 1'b0, 0, 1'b0, 4'd0);
        lru_sweep(d, ln, tt, "R5");
    endtask

    // ---------------- LRR helpers ----------------
    function automatic int get_lrr();
        return c_vn ? 100 + int'(c_vw) : int'(c_vw);
    endfunction

    function automatic int lrr_exp(input int ln, input logic [1:0] lk);
        int s;
        s = nb[ln];
        if (!lk[s])     return s;
        if (!lk[1 - s]) return 1 - s;
        return 100;
    endfunction

    task automatic lrr_step(input int ln, input bit acc, input int aw, input bit rf,
                            input logic [1:0] lk);
        int ev;
        @(negedge clk);
        c_idx = 2'(ln); c_acc = acc; c_aw = 1'(aw); c_rf = rf; c_lk = lk;
        #1;
        ev = lrr_exp(ln, lk);
        if (rf) chk(ev == 100 ? "R7" : (lk != 0 ? "R6" : "R3"), get_lrr(), ev);
        @(posedge clk);
        if (rf && ev != 100) nb[ln] = 1 - ev;
        @(negedge clk);
        c_acc = 1'b0; c_rf = 1'b0;
        for (int l = 0; l < 4; l++) begin
            for (int k = 0; k < 4; k++) begin
                c_idx = 2'(l); c_lk = 2'(k);
                #1;
                chk(k == 3 ? "R7" : (k != 0 ? "R6" : (l == ln ? "R3" : "R5")),
                    get_lrr(), lrr_exp(l, 2'(k)));
            end
        end
    endtask

    function automatic logic [3:0] pick_lock(input int unsigned r, input int full);
        if (((r >> 4) & 7) == 0) return 4'(full);
        if (((r >> 7) & 1) == 1) return 4'((r >> 8) & full);
        return 4'd0;
    endfunction

    // ---------------- main sequence ----------------
    initial begin
        a_idx = '0; a_acc = 0; a_aw = '0; a_rf = 0; a_lk = '0;
        b_idx = '0; b_acc = 0; b_aw = '0; b_rf = 0; b_lk = '0;
        c_idx = '0; c_acc = 0; c_aw = '0; c_rf = 0; c_lk = '0;
        d_lk  = '0;
        e_idx = '0; e_acc = 0; e_aw = '0; e_rf = 0; e_lk = '0;
        mw[0] = 4; mw[1] = 3;
        for (int d = 0; d < 2; d++)
            for (int l = 0; l < 4; l++)
                for (int i = 0; i < 4; i++) mo[d][l][i] = i;
        for (int l = 0; l < 4; l++) nb[l] = 0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state seen before the first active edge
        chk("R1", get_lru(0), 0);
        chk("R1", get_lru(1), 0);
        chk("R1", get_lrr(), 0);
        chk("R1", d_vn ? 100 : int'(d_vw), 0);
        chk("R1", e_vn ? 100 : int'(e_vw), 0);
        @(negedge clk);
        lru_sweep(0, -1, "R1", "R1");
        lru_sweep(1, -1, "R1", "R1");

        // R4 directed: access ways 0,1,2 on line 1 of 4-way; oldest becomes 3
        lru_step(0, 1, 1'b1, 0, 1'b0, 4'd0);
        lru_step(0, 1, 1'b1, 1, 1'b0, 4'd0);
        lru_step(0, 1, 1'b1, 2, 1'b0, 4'd0);
        @(negedge clk);
        a_idx = 2'd1; a_lk = 4'd0; #1;
        chk("R4", get_lru(0), 3);

        // LRU sweeps with mixed stimulus
        for (int d = 0; d < 2; d++) begin
            for (int s = 0; s < 150; s++) begin
                int unsigned r;
                int          op;
                r  = rnd();
                op = int'((r >> 2) & 3);
                lru_step(d, int'(r & 3), op != 1, int'((r >> 12) & 3), op >= 2,
                         pick_lock(r >> 14, (1 << mw[d]) - 1));
            end
        end

        // LRR sweep
        for (int s = 0; s < 120; s++) begin
            int unsigned r;
            r = rnd();
            lrr_step(int'(r & 3), ((r >> 2) & 1) == 1, int'((r >> 3) & 1),
                     ((r >> 4) & 1) == 1, pick_lock(r >> 6, 3) [1:0]);
        end

        // R2 random counter with rotating lock skip
        for (int s = 0; s < 120; s++) begin
            int unsigned r;
            int          ev;
            @(negedge clk);
            r    = rnd();
            d_lk = (s < 16) ? 4'd0 : pick_lock(r, 15);
            #1;
            ev = 100;
            for (int k = 3; k >= 0; k--) begin
                if (!d_lk[(mc + k) % 4]) ev = (mc + k) % 4;
            end
            chk(d_lk == 4'hF ? "R7" : (d_lk != 0 ? "R6" : "R2"),
                d_vn ? 100 + int'(d_vw) : int'(d_vw), ev);
        end

        // R8 direct mapped
        for (int s = 0; s < 16; s++) begin
            @(negedge clk);
            e_idx = 2'(s); e_acc = s[1]; e_rf = s[2]; e_lk = s[0]; e_aw = '0;
            @(posedge clk);
            @(negedge clk);
            #1;
            chk("R8", e_vn ? 100 + int'(e_vw) : int'(e_vw), s[0] ? 100 : 0);
        end

        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog (R1..R10 run): actual %0d expected %0d", 1, 0);
        finish_run();
    end

endmodule